// File: doc/BRIEF.md
# Dual-Channel 8x Interpolating Filter

This block raises the sample rate of a stereo stream of 16-bit two's complement samples by a factor of eight. It is a chain of three half-band interpolators, each doubling the rate of the one before. Every stage splits its kernel into two polyphase branches. The even branch reduces to a pure delay of the stored sample, so the stage only computes the odd branch. It does so with one multiply-accumulate per channel, and a pre-adder folds each symmetric pair of taps. The three kernels span 153, 29 and 17 taps (4·HALF+1 with HALF = 38, 7 and 4). The first stage sets the overall band edge: the passband runs to about 0.45 of the input rate and the stopband starts near 0.55 of it.

The taps come from an elaboration-time function: an ideal half-band response 2/(π·d) at odd distance d, shaped by the window (1 − d²/L²)², with L = 2·HALF+1, in Q17. The samples between stages carry 8 fraction bits and 2 headroom bits. An output formatter rounds the final value to 16, 18 or 20 bits, chosen at run time, and saturates it. Left and right run in lockstep on a shared schedule and share a single output strobe.

Top module: `interp8x_dual`

## Requirements
- R1: Each input strobe, given at least 64 cycles after the previous one, yields exactly eight `out_vld` pulses. The first pulse follows the rising edge that is fourth when the edge sampling `in_vld` counts as first. `out_left`/`out_right` change only on edges that raise `out_vld`.
- R2: With default parameters, output sample 8n+4 (counting from 0 after reset) equals input sample n−42 exactly, scaled to the selected width.
- R3: The impulse response is symmetric about its peak, with the peak at output 340 after the impulse. Output 344 equals the impulse times the first stage's nearest tap 83415/2^17, within 2 LSB.
- R4: Left and right are filtered independently: data on one channel never appears on the other.
- R5: `width_sel` 0 selects 16 bits, 1 selects 18 bits, and 2 or 3 select 20 bits. The result is right-justified and sign-extended in the 20-bit port, so an exactly representable input x appears as x, 4x or 16x.
- R6: Results are rounded to nearest (ties up), then clamped to the signed range of the selected width. Full-scale steps drive the output to both limits exactly.
- R7: A constant input settles to an output within 3% of that constant.
- R8: Reset clears every delay line: zero input after a reset gives zero output, whatever data came before.
- R9: After reset no `out_vld` pulse occurs until an input strobe, and both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One-cycle strobe: a new sample pair is present |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| width_sel | input | 2 | Output word width: 0=16, 1=18, 2/3=20 bits |
| out_vld | output | 1 | One-cycle strobe per output sample pair |
| out_left | output | 20 | Left output, right-justified, sign-extended |
| out_right | output | 20 | Right output, right-justified, sign-extended |

## Verification
The bench checks the exact passthrough of the even polyphase branch across all three stages. A wrong delay-line tap or a swapped branch order would shift or corrupt every eighth sample. Impulse symmetry and the value next to the peak expose a wrong pre-add pairing or a wrong coefficient index, which would make the response lopsided or zero between samples. Full-scale steps in two widths target the clamp, where a missing or misplaced limit would wrap to the opposite sign. A reset issued with data in flight, followed by silence, catches delay lines that keep stale samples.

// File: rtl/interp8x_pkg.sv
package interp8x_pkg;

  localparam int COEF_FRAC = 17;
  localparam int COEF_W    = 19;

  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_FIN} stage_state_e;

  // Odd-branch tap j (distance d = 2j+1 from centre) of a half-band kernel
  // with HALF folded pairs: windowed 2/(pi*d), Q17, rounded to nearest.
  function automatic longint hb_coef(input int j, input int half);
    longint d, l, l2, l4, g, num, den, mag;
    d   = longint'(2 * j + 1);
    l   = longint'(2 * half + 1);
    l2  = l * l;
    l4  = l2 * l2;
    g   = l2 - d * d;
    num = longint'(83443) * g * g;
    den = d * l4;
    mag = (2 * num + den) / (2 * den);
    return (j % 2 == 1) ? -mag : mag;
  endfunction

endpackage

// File: rtl/interp8x_hb_stage.sv
module interp8x_hb_stage
  import interp8x_pkg::*;
#(
  parameter int HALF = 38,
  parameter int DW   = 26,
  parameter int CH   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data  [CH],
  output logic                 out_vld,
  output logic signed [DW-1:0] out_data [CH]
);

  localparam int TAPS   = 2 * HALF;
  localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int IDX_W  = $clog2(TAPS);
  localparam int PRE_W  = DW + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(HALF) + 1;

  localparam logic signed [ACC_W-1:0] RND   = ACC_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] Y_MAX = (ACC_W'(1) <<< (DW - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -(ACC_W'(1) <<< (DW - 1));

  stage_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             last_mac;
  logic [IDX_W-1:0] idx_near;
  logic [IDX_W-1:0] idx_far;

  logic signed [COEF_W-1:0] coef_rom [HALF];
  logic signed [COEF_W-1:0] coef_cur;

  for (genvar g = 0; g < HALF; g++) begin : g_rom
    assign coef_rom[g] = COEF_W'(hb_coef(g, HALF));
  end

  assign take     = in_vld && (state == ST_IDLE);
  assign last_mac = (cnt == CNT_W'(HALF - 1));
  assign idx_near = IDX_W'(HALF - 1) - IDX_W'(cnt);
  assign idx_far  = IDX_W'(HALF) + IDX_W'(cnt);
  assign coef_cur = coef_rom[cnt];

  // Shared sequencer: phase 0 on accept, HALF MAC cycles, phase 1 on finish.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      unique case (state)
        ST_IDLE: if (in_vld) begin
          state   <= ST_MAC;
          cnt     <= '0;
          out_vld <= 1'b1;
        end
        ST_MAC: begin
          if (last_mac) state <= ST_FIN;
          else          cnt   <= cnt + CNT_W'(1);
        end
        ST_FIN: begin
          state   <= ST_IDLE;
          out_vld <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic signed [DW-1:0]     dl [TAPS];
    logic signed [ACC_W-1:0]  acc;
    logic signed [DW-1:0]     y;
    logic signed [PRE_W-1:0]  pre;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  rounded;

    assign pre     = PRE_W'(dl[idx_near]) + PRE_W'(dl[idx_far]);
    assign prod    = pre * coef_cur;
    assign rounded = (acc + RND) >>> COEF_FRAC;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < TAPS; i++) dl[i] <= '0;
        acc <= '0;
        y   <= '0;
      end else if (take) begin
        dl[0] <= in_data[c];
        for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
        y   <= dl[HALF-1];
        acc <= '0;
      end else if (state == ST_MAC) begin
        acc <= acc + ACC_W'(prod);
      end else if (state == ST_FIN) begin
        if (rounded > Y_MAX)      y <= DW'(Y_MAX);
        else if (rounded < Y_MIN) y <= DW'(Y_MIN);
        else                      y <= DW'(rounded);
      end
    end

    assign out_data[c] = y;
  end

endmodule

// File: rtl/interp8x_out_fmt.sv
module interp8x_out_fmt #(
  parameter int DW     = 26,
  parameter int FRAC   = 8,
  parameter int BASE_W = 16,
  parameter int OW     = 20,
  parameter int CH     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data  [CH],
  input  logic [1:0]           width_sel,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data [CH]
);

  localparam int EW    = DW + 1;
  localparam int MID_W = (BASE_W + OW) / 2;

  function automatic logic signed [OW-1:0] fmt(input logic signed [DW-1:0] v,
                                               input logic [1:0] sel);
    int w;
    int sh;
    logic signed [EW-1:0] t, hi, lo;
    case (sel)
      2'd0:    w = BASE_W;
      2'd1:    w = MID_W;
      default: w = OW;
    endcase
    sh = FRAC - (w - BASE_W);
    t  = (EW'(v) + (EW'(1) <<< (sh - 1))) >>> sh;
    hi = (EW'(1) <<< (w - 1)) - EW'(1);
    lo = -(EW'(1) <<< (w - 1));
    if (t > hi) return OW'(hi);
    if (t < lo) return OW'(lo);
    return OW'(t);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      for (int c = 0; c < CH; c++) out_data[c] <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld)
        for (int c = 0; c < CH; c++) out_data[c] <= fmt(in_data[c], width_sel);
    end
  end

endmodule

// File: rtl/interp8x_dual.sv
module interp8x_dual #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 20,
  parameter int FRAC_G = 8,
  parameter int HALF_A = 38,
  parameter int HALF_B = 7,
  parameter int HALF_C = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_left,
  input  logic signed [IN_W-1:0]  in_right,
  input  logic [1:0]              width_sel,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_left,
  output logic signed [OUT_W-1:0] out_right
);

  localparam int CH     = 2;
  localparam int NSTAGE = 3;
  localparam int DW     = IN_W + FRAC_G + 2;

  logic signed [DW-1:0]    lnk_d [NSTAGE+1][CH];
  logic                    lnk_v [NSTAGE+1];
  logic signed [OUT_W-1:0] fmt_d [CH];

  assign lnk_v[0]    = in_vld;
  assign lnk_d[0][0] = {{2{in_left[IN_W-1]}},  in_left,  {FRAC_G{1'b0}}};
  assign lnk_d[0][1] = {{2{in_right[IN_W-1]}}, in_right, {FRAC_G{1'b0}}};

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int H = (s == 0) ? HALF_A : (s == 1) ? HALF_B : HALF_C;
    interp8x_hb_stage #(.HALF(H), .DW(DW), .CH(CH)) u_hb (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (lnk_v[s]),
      .in_data  (lnk_d[s]),
      .out_vld  (lnk_v[s+1]),
      .out_data (lnk_d[s+1])
    );
  end

  interp8x_out_fmt #(.DW(DW), .FRAC(FRAC_G), .BASE_W(IN_W), .OW(OUT_W), .CH(CH)) u_fmt (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (lnk_v[NSTAGE]),
    .in_data   (lnk_d[NSTAGE]),
    .width_sel (width_sel),
    .out_vld   (out_vld),
    .out_data  (fmt_d)
  );

  assign out_left  = fmt_d[0];
  assign out_right = fmt_d[1];

endmodule

// File: rtl/interp8x_dual_chk.sv
module interp8x_dual_chk #(
  parameter int OUT_W  = 20,
  parameter int BASE_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_vld,
  input logic [1:0]              width_sel,
  input logic                    out_vld,
  input logic signed [OUT_W-1:0] out_left,
  input logic signed [OUT_W-1:0] out_right
);

  int       lim_w;
  int       hi_v;
  int       lo_v;
  logic [3:0] since_in;
  logic       seen_in;

  always_comb begin
    case (width_sel)
      2'd0:    lim_w = BASE_W;
      2'd1:    lim_w = (BASE_W + OUT_W) / 2;
      default: lim_w = OUT_W;
    endcase
    hi_v = (1 <<< (lim_w - 1)) - 1;
    lo_v = -(1 <<< (lim_w - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_in <= '0;
      seen_in  <= 1'b0;
    end else if (in_vld) begin
      since_in <= '0;
      seen_in  <= 1'b1;
    end else if (out_vld && since_in != 4'hF) begin
      since_in <= since_in + 4'd1;
    end
  end

  assert_range_left_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_left) <= hi_v && int'(out_left) >= lo_v));

  assert_range_right_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_right) <= hi_v && int'(out_right) >= lo_v));

  assert_eight_per_input_R1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (since_in < 4'd8));

  assert_quiet_after_input_R1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> !out_vld);

  assert_hold_left_R1: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_left));

  assert_hold_right_R1: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_right));

  assert_idle_until_input_R9: assert property (@(posedge clk) disable iff (rst)
    !seen_in |-> !out_vld);

endmodule

bind interp8x_dual interp8x_dual_chk #(.OUT_W(OUT_W), .BASE_W(IN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_vld    (in_vld),
  .width_sel (width_sel),
  .out_vld   (out_vld),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/interp8x_dual_test.sv
module interp8x_dual_test;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 64;
  localparam int CAP        = 1024;
  localparam int DLY        = 42;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_vld = 1'b0;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic [1:0]         width_sel = 2'd0;
  logic               out_vld;
  logic signed [19:0] out_left;
  logic signed [19:0] out_right;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cap_n   = 0;
  int cap_l [CAP];
  int cap_r [CAP];

  interp8x_dual uut (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_left   (in_left),
    .in_right  (in_right),
    .width_sel (width_sel),
    .out_vld   (out_vld),
    .out_left  (out_left),
    .out_right (out_right)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_vld && cap_n < CAP) begin
      cap_l[cap_n] = int'(out_left);
      cap_r[cap_n] = int'(out_right);
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int xs(input int n);
    return ((n * 7919) % 60001) - 30000;
  endfunction

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0; width_sel = sel;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cap_n = 0;
  endtask

  task automatic send(input int l, input int r);
    @(negedge clk);
    in_vld = 1'b1; in_left = 16'(l); in_right = 16'(r);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic t_reset_idle;
    int strobes = 0;
    do_reset(2'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_vld) strobes++;
    end
    chk(strobes == 0, "R9", "strobes before any input", strobes, 0);
    chk(out_left == 0 && out_right == 0, "R9", "outputs after reset",
        longint'(out_left) + longint'(out_right), 0);
  endtask

  task automatic t_latency;
    do_reset(2'd0);
    @(negedge clk);
    in_vld = 1'b1; in_left = 16'sd1000; in_right = 16'sd0;
    @(negedge clk);
    in_vld = 1'b0;
    chk(!out_vld, "R1", "out_vld after 1st edge", out_vld, 0);
    @(negedge clk);
    chk(!out_vld, "R1", "out_vld after 2nd edge", out_vld, 0);
    @(negedge clk);
    chk(!out_vld, "R1", "out_vld after 3rd edge", out_vld, 0);
    @(negedge clk);
    chk(out_vld, "R1", "out_vld after 4th edge", out_vld, 1);
    repeat (GAP) @(negedge clk);
    chk(cap_n == 8, "R1", "strobes per input", cap_n, 8);
  endtask

  task automatic t_pass(input logic [1:0] sel, input int scale, input int n_in);
    int bad = 0;
    int first_a = 0;
    int first_e = 0;
    do_reset(sel);
    for (int n = 0; n < n_in; n++) send(xs(n), -xs(n));
    repeat (GAP) @(negedge clk);
    chk(cap_n == 8 * n_in, "R1", "strobe count", cap_n, 8 * n_in);
    for (int n = DLY; n < n_in; n++) begin
      if (cap_l[8*n+4] != xs(n - DLY) * scale || cap_r[8*n+4] != -xs(n - DLY) * scale) begin
        if (bad == 0) begin first_a = cap_l[8*n+4]; first_e = xs(n - DLY) * scale; end
        bad++;
      end
    end
    chk(bad == 0, "R2", "passthrough samples", first_a, first_e);
    chk(bad == 0, "R5", $sformatf("width_sel %0d scaling", sel), first_a, first_e);
  endtask

  task automatic t_impulse;
    int asym = 0;
    int leak = 0;
    int mid;
    do_reset(2'd0);
    send(20000, 0);
    for (int n = 1; n < 86; n++) send(0, 0);
    repeat (GAP) @(negedge clk);
    chk(cap_l[340] == 20000, "R3", "impulse peak", cap_l[340], 20000);
    mid = cap_l[344];
    chk(mid >= 12726 && mid <= 12730, "R3", "sample next to peak", mid, 12728);
    for (int k = 1; k <= 340; k++)
      if (cap_l[340 + k] != cap_l[340 - k]) asym++;
    chk(asym == 0, "R3", "asymmetric pairs", asym, 0);
    for (int i = 0; i < cap_n; i++)
      if (cap_r[i] != 0) leak++;
    chk(leak == 0, "R4", "nonzero right samples", leak, 0);
  endtask

  task automatic t_cross_right;
    int leak = 0;
    do_reset(2'd2);
    for (int n = 0; n < 50; n++) send(0, xs(n));
    repeat (GAP) @(negedge clk);
    for (int i = 0; i < cap_n; i++)
      if (cap_l[i] != 0) leak++;
    chk(leak == 0, "R4", "nonzero left samples", leak, 0);
  endtask

  task automatic t_dc;
    int worst = 0;
    do_reset(2'd0);
    for (int n = 0; n < 100; n++) send(10000, -10000);
    repeat (GAP) @(negedge clk);
    for (int i = 8 * 90; i < 8 * 100; i++) begin
      int e;
      e = cap_l[i] - 10000;
      if (e < 0) e = -e;
      if (e > worst) worst = e;
      e = cap_r[i] + 10000;
      if (e < 0) e = -e;
      if (e > worst) worst = e;
    end
    chk(worst <= 300, "R7", "settled DC error", worst, 300);
  endtask

  task automatic t_sat(input logic [1:0] sel, input int hi, input int lo);
    int mx = -(1 << 30);
    int mn = (1 << 30);
    do_reset(sel);
    for (int n = 0; n < 60; n++)
      if ((n / 6) % 2 == 0) send(32767, -32768);
      else                  send(-32768, 32767);
    repeat (GAP) @(negedge clk);
    for (int i = 0; i < cap_n; i++) begin
      if (cap_l[i] > mx) mx = cap_l[i];
      if (cap_l[i] < mn) mn = cap_l[i];
      if (cap_r[i] > mx) mx = cap_r[i];
      if (cap_r[i] < mn) mn = cap_r[i];
    end
    chk(mx == hi, "R6", $sformatf("max, width_sel %0d", sel), mx, hi);
    chk(mn == lo, "R6", $sformatf("min, width_sel %0d", sel), mn, lo);
  endtask

  task automatic t_reset_clears;
    int nz = 0;
    do_reset(2'd2);
    for (int n = 0; n < 30; n++) send(xs(n), xs(n + 3));
    do_reset(2'd2);
    for (int n = 0; n < 20; n++) send(0, 0);
    repeat (GAP) @(negedge clk);
    chk(cap_n == 160, "R8", "strobes after reset", cap_n, 160);
    for (int i = 0; i < cap_n; i++)
      if (cap_l[i] != 0 || cap_r[i] != 0) nz++;
    chk(nz == 0, "R8", "stale nonzero samples", nz, 0);
  endtask

  initial begin
    t_reset_idle();
    t_latency();
    t_pass(2'd0, 1, 60);
    t_pass(2'd1, 4, 50);
    t_pass(2'd3, 16, 50);
    t_impulse();
    t_cross_right();
    t_dc();
    t_sat(2'd0, 32767, -32768);
    t_sat(2'd2, 524287, -524288);
    t_reset_clears();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: actual unfinished expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule